// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block sends one 7-bit character at a time over a single asynchronous serial line. The host presents the character on a parallel input and chooses even or odd parity. It then raises a request and holds it. The block answers with a busy flag, shifts out a ten-bit frame, lowers the flag when the frame is complete, and waits for the host to withdraw the request before it will accept another character.

Inside the block, a divider derives a one-cycle bit strobe from the system clock, a modulo-ten counter tracks the bit times, and a 9-bit parallel-in/serial-out register holds the frame. A small state machine sequences these parts. The register loads a 0 start bit at its low end, the data in the middle and the parity bit at its high end. It shifts toward the line output and fills with 1 from the top, so a 1 stop bit follows the parity bit. The clock frequency and bit rate are parameters: the defaults give 300 bit/s, and a bench can pick a small divide ratio.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `busy` is 0.
- R2: A frame consists of a 0 start bit, then `data[0]` through `data[6]` in that order, then the parity bit, then a 1 stop bit.
- R3: The parity bit is the XOR of the seven data bits XORed with `odd_sel`. When `odd_sel` is 0, the count of ones over data and parity is even. When `odd_sel` is 1, that count is odd.
- R4: Each of the ten bits is held on `tx_line` for exactly DIV = CLK_HZ/BAUD clock cycles. The line changes only at a bit boundary.
- R5: When `send` is sampled high in idle, `busy` goes to 1 and the start bit appears on `tx_line` after that same clock edge. The start bit lasts a full bit time.
- R6: `busy` stays high for exactly 10*DIV cycles and falls at the edge that ends the stop bit. `tx_line` is 1 from that edge on.
- R7: If `send` is still high after `busy` falls, no new frame starts. `busy` stays 0 and the line stays 1 until `send` has been sampled low.
- R8: `data` and `odd_sel` are captured at the start of a frame. Changing them while `busy` is high has no effect on the bits sent.
- R9: If `send` is low for a single cycle after `busy` falls and then goes high again, a new frame starts at the next edge with no further gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| send | input | 1 | Host request; raised and held until `busy` has fallen |
| odd_sel | input | 1 | Parity choice: 0 even, 1 odd |
| data | input | DATA_W (7) | Character to send |
| busy | output | 1 | High while a frame is being sent |
| tx_line | output | 1 | Serial line output, 1 when idle |

## Verification
A wrong phase in the bit strobe shows as a line transition that comes too early or too late. A reference model that tracks every cycle exposes this within one bit time. A bit counter that is off by one shows as a `busy` pulse one bit time too long or too short, and this appears at the end of the first frame. A shift register that is loaded or filled wrongly shows as a wrong level in the affected bit slot, so the fault is seen during the same frame. A state machine that skips the wait for `send` to go low starts a second frame while `send` is still held high after `busy` falls, and this is visible on `busy` one cycle later.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_LOAD  = 2'd1,
    SH_SHIFT = 2'd2,
    SH_CLEAR = 2'd3
  } sh_op_e;

endpackage

// File: rtl/tx_tick_gen.sv
module tx_tick_gen #(
  parameter int unsigned DIV = 333333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart || cnt_q == LAST) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = !restart && (cnt_q == LAST);
endmodule

// File: rtl/tx_bit_counter.sv
module tx_bit_counter #(
  parameter int unsigned LIMIT = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(LIMIT+1)-1:0]   count,
  output logic                         wrap
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (inc)         cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign wrap  = inc && (cnt_q == TOP);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import serial_tx_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sh_op_e       op,
  input  logic [W-1:0] load_val,
  output logic         ser_out
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    unique case (op)
      SH_LOAD:  sr_d = load_val;
      SH_SHIFT: sr_d = {1'b1, sr_q[W-1:1]};
      SH_CLEAR: sr_d = '1;
      default:  sr_d = sr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign ser_out = sr_q[0];
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned BAUD   = 300,
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              tx_line
);
  localparam int unsigned DIV    = CLK_HZ / BAUD;
  localparam int unsigned SR_W   = DATA_W + 2;
  localparam int unsigned BITS   = DATA_W + 3;
  localparam int unsigned BCW    = $clog2(BITS + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  tx_state_e       state_q, state_d;
  sh_op_e          sh_op;
  logic            tick, restart, cnt_clr, cnt_inc, bit_wrap;
  logic [BCW-1:0]  bit_cnt;
  logic            par_bit;
  logic [SR_W-1:0] frame_img;

  assign par_bit   = (^data) ^ odd_sel;
  assign frame_img = {par_bit, data, 1'b0};

  tx_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .tick(tick)
  );

  tx_bit_counter #(.LIMIT(BITS)) u_bits (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .inc(cnt_inc),
    .count(bit_cnt), .wrap(bit_wrap)
  );

  tx_frame_shifter #(.W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .op(sh_op), .load_val(frame_img),
    .ser_out(tx_line)
  );

  always_comb begin
    state_d = state_q;
    sh_op   = SH_HOLD;
    restart = 1'b1;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (send) begin
        sh_op   = SH_LOAD;
        cnt_clr = 1'b1;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        restart = 1'b0;
        if (tick) begin
          sh_op   = SH_SHIFT;
          cnt_inc = 1'b1;
          if (bit_wrap) state_d = ST_DONE;
        end
      end
      ST_DONE: if (!send) state_d = ST_IDLE;
      default: begin
        sh_op   = SH_CLEAR;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  assign busy = (state_q == ST_SEND);

  // R1: line rests high outside a frame
  a_r1_line_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_SEND) |-> tx_line);

  // R5: a frame opens with the start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> !tx_line);

  // R4: the line moves only on a bit strobe
  a_r4_line_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !tick) |=> $stable(tx_line));

  // R7: at least one idle cycle follows every frame
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |=> !busy);

  // R2: bit index stays inside the frame
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_cnt <= BCW'(BITS - 1));

  // R6: busy drops only where the bit counter wrapped
  a_r6_end_on_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && tick && bit_wrap) |=> (!busy && tx_line));
endmodule

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
  localparam int CLK_HZ = 1_000_000;
  localparam int BAUD   = 125_000;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int BITS   = 10;

  logic       clk = 1'b0;
  logic       rst_n, send, odd_sel;
  logic [6:0] data;
  logic       busy, tx_line;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .send(send), .odd_sel(odd_sel),
    .data(data), .busy(busy), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit frame_bit(input int b, input logic [6:0] d, input logic o);
    if (b == 0)      return 1'b0;
    else if (b <= 7) return d[b-1];
    else if (b == 8) return (^d) ^ o;
    else             return 1'b1;
  endfunction

  // behavioural reference: queue of per-cycle line levels
  bit q[$];
  int phase; // 0 idle, 1 sending, 2 waiting for send low
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      phase = 0;
    end else begin
      case (phase)
        0: if (send) begin
          for (int b = 0; b < BITS; b++)
            for (int c = 0; c < DIV; c++) q.push_back(frame_bit(b, data, odd_sel));
          phase = 1;
        end
        1: begin
          void'(q.pop_front());
          if (q.size() == 0) phase = 2;
        end
        default: if (!send) phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (phase == 1) chk(tx_line === q[0], "R2 model line", tx_line, q[0]);
      else            chk(tx_line === 1'b1, "R1 model line", tx_line, 1);
      chk(busy === (phase == 1), "R6 model busy", busy, phase == 1);
    end
  end

  task automatic send_frame(input logic [6:0] d, input logic o, input int hold, input int low);
    logic [9:0] bits;
    int k;
    data = d; odd_sel = o; send = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R5/R9 busy rise", busy, 1);
    chk(tx_line === 1'b0, "R5 start bit", tx_line, 0);
    k = 0; bits = '0;
    while (busy && k < 200) begin
      if (k % DIV == DIV / 2) bits[k / DIV] = tx_line;
      if (k == 20) begin data = ~d; odd_sel = ~o; end
      k++;
      @(negedge clk);
    end
    chk(k == BITS * DIV, "R6/R4 frame length", k, BITS * DIV);
    for (int b = 0; b < BITS; b++)
      chk(bits[b] == frame_bit(b, d, o), (b == 8) ? "R3 parity" : "R2/R8 bit",
          bits[b], frame_bit(b, d, o));
    chk(tx_line === 1'b1, "R6 line after", tx_line, 1);
    for (int h = 0; h < hold; h++) begin
      chk(busy === 1'b0 && tx_line === 1'b1, "R7 held send", busy, 0);
      @(negedge clk);
    end
    send = 1'b0;
    for (int l = 0; l < low; l++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; send = 1'b0; odd_sel = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1, "R1 reset line", tx_line, 1);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    data = 7'h55; odd_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1 && busy === 1'b0, "R1 idle", tx_line, 1);
    send_frame(7'h57, 1'b0, 2 * DIV, 3);
    send_frame(7'h57, 1'b1, 3, 2);
    send_frame(7'h00, 1'b0, 1, 1);
    send_frame(7'h7F, 1'b1, 0, 1);
    send_frame(7'h2A, 1'b0, 0, 1);
    send_frame(7'h01, 1'b1, 3 * DIV, 4);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule